// File: doc/BRIEF.md
# Shared-Memory Ring FIFO Accessor

This block lets local logic exchange bytes with a processor through single-byte ring FIFOs that live in that processor's memory. Each ring is a power-of-two buffer preceded by a three-byte header holding the size mask, the producer index and the consumer index. The block keeps a small table of ring descriptors, each with the base address, mask, producer index and consumer index. The caller selects a descriptor with an index input and issues one of six commands: bind a ring, test for empty, test for full, take a byte without waiting, take a byte waiting for data, and append a byte.

The block does not generate bus cycles itself. It asks for bus ownership through a request/grant pair. It then issues byte reads and writes through a memory-cycle handshake. Every command that touches memory does all its accesses inside one ownership and drops the request before it answers. The waiting commands release the bus between polls. A refused request ends the command with an error and leaves every index unchanged.

Top module: `ring_fifo_accessor`

## Requirements
- R1: After reset `cmd_ready` is 1, `bus_req`, `mem_req` and `rsp_valid` are 0, and every descriptor is unbound (base 0).
- R2: Ring header bytes sit below the base: mask at base-3, producer index at base-2, consumer index at base-1, with addresses wrapping modulo 2^AW.
- R3: Command code 0 (bind) stores `cmd_base` in the selected descriptor. For a nonzero base it reads mask, producer index and consumer index, in that order, within one ownership. For base 0 it makes no bus request.
- R4: Command code 1 (empty) answers `rsp_flag`=1 exactly when the producer index read from memory equals the local consumer index. An unbound ring answers 1 with no bus request.
- R5: Command code 2 (full) answers `rsp_flag`=1 exactly when (local producer index + 1) AND mask equals the consumer index read from memory. An unbound ring answers 0 with no bus request.
- R6: Command code 3 (take, no wait) on a non-empty ring reads base + consumer index and returns it in `rsp_data` with `rsp_flag`=0. It then writes (index + 1) AND mask to base-1. On an empty ring it answers `rsp_flag`=1 after a single read. On an unbound ring it answers `rsp_flag`=1 with no bus request.
- R7: Command code 4 (take, waiting) repeats the empty poll, releasing the bus between polls, until data is present, then behaves as R6. An unbound ring answers `rsp_flag`=1 at once.
- R8: Command code 5 (append) polls while the ring is full, releasing between polls. It then writes `cmd_wdata` to base + producer index and writes (index + 1) AND mask to base-2. An unbound ring answers `rsp_flag`=1 with no bus request.
- R9: A `bus_fail` pulse while a request is pending ends the command with `rsp_err`=1, no memory cycle and no change to any index.
- R10: `mem_req` is asserted only while `bus_req` and `bus_gnt` are both high, and address, direction and write data hold steady until `mem_done`.
- R11: `rsp_valid` is a one-cycle pulse given only while `bus_req` is low. Command codes 6 and 7 answer `rsp_err`=1 with no bus request.
- R12: Descriptors are independent: a command on one index never alters the state used by another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | Command code (0..5 as in R3-R8) |
| cmd_sel | input | SELW | Descriptor index |
| cmd_base | input | AW | Ring base address for bind |
| cmd_wdata | input | DW | Byte to append |
| rsp_valid | output | 1 | Response pulse |
| rsp_flag | output | 1 | Empty/full/no-data indication |
| rsp_err | output | 1 | Bus refused or bad command |
| rsp_data | output | DW | Byte taken |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Ownership granted (level) |
| bus_fail | input | 1 | Request refused (pulse) |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_done | input | 1 | Memory cycle complete, read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The checker watches the bus discipline every cycle. Memory cycles happen only under a held grant, a pending cycle keeps its address and data steady, and a response is a single pulse that comes only after the bus is released. Only the scenarios can show the data-side behaviour: which header and buffer addresses are touched and in what order, the mask wrap of both indices, header addresses wrapping below zero, the polling of the waiting commands against a concurrent producer or consumer, and the untouched indices after a refused request.

// File: rtl/ring_fifo_accessor.sv
module ring_fifo_accessor #(
  parameter int NFIFO = 4,
  parameter int AW    = 20,
  parameter int DW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [2:0]           cmd_op,
  input  logic [(NFIFO>1 ? $clog2(NFIFO) : 1)-1:0] cmd_sel,
  input  logic [AW-1:0]        cmd_base,
  input  logic [DW-1:0]        cmd_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_flag,
  output logic                 rsp_err,
  output logic [DW-1:0]        rsp_data,
  output logic                 bus_req,
  input  logic                 bus_gnt,
  input  logic                 bus_fail,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_done,
  input  logic [DW-1:0]        mem_rdata
);
  localparam int SELW = NFIFO > 1 ? $clog2(NFIFO) : 1;
  localparam logic [2:0] OP_BIND = 3'd0, OP_EMPTY = 3'd1, OP_FULL = 3'd2,
                         OP_TAKE = 3'd3, OP_WAIT = 3'd4, OP_PUT = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_MEM, S_REL, S_RSP} st_t;

  st_t             st;
  logic [2:0]      op_q;
  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   wd_q, dout_q;
  logic [1:0]      step;
  logic            flag_q, err_q, retry_q;

  logic [AW-1:0] d_base [NFIFO];
  logic [DW-1:0] d_mask [NFIFO];
  logic [DW-1:0] d_in   [NFIFO];
  logic [DW-1:0] d_out  [NFIFO];

  wire [AW-1:0] cur_base = d_base[sel_q];
  wire [DW-1:0] cur_mask = d_mask[sel_q];
  wire [DW-1:0] cur_in   = d_in[sel_q];
  wire [DW-1:0] cur_out  = d_out[sel_q];
  wire [DW-1:0] in_nxt   = DW'(cur_in + 1'b1) & cur_mask;
  wire [DW-1:0] out_nxt  = DW'(cur_out + 1'b1) & cur_mask;
  wire [AW-1:0] a_mask   = cur_base - AW'(3);
  wire [AW-1:0] a_in     = cur_base - AW'(2);
  wire [AW-1:0] a_out    = cur_base - AW'(1);
  wire          is_take  = (op_q == OP_TAKE) || (op_q == OP_WAIT);

  assign cmd_ready = (st == S_IDLE);
  assign bus_req   = (st == S_REQ) || (st == S_MEM);
  assign mem_req   = (st == S_MEM);
  assign rsp_valid = (st == S_RSP);
  assign rsp_flag  = flag_q;
  assign rsp_err   = err_q;
  assign rsp_data  = dout_q;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = a_in;
    mem_wdata = '0;
    case (op_q)
      OP_BIND:  mem_addr = (step == 2'd0) ? a_mask : (step == 2'd1) ? a_in : a_out;
      OP_EMPTY: mem_addr = a_in;
      OP_FULL:  mem_addr = a_out;
      OP_TAKE, OP_WAIT: begin
        if (step == 2'd0)      mem_addr = a_in;
        else if (step == 2'd1) mem_addr = cur_base + AW'(cur_out);
        else begin
          mem_we    = 1'b1;
          mem_addr  = a_out;
          mem_wdata = out_nxt;
        end
      end
      OP_PUT: begin
        if (step == 2'd0) mem_addr = a_out;
        else if (step == 2'd1) begin
          mem_we    = 1'b1;
          mem_addr  = cur_base + AW'(cur_in);
          mem_wdata = wd_q;
        end else begin
          mem_we    = 1'b1;
          mem_addr  = a_in;
          mem_wdata = in_nxt;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      sel_q   <= '0;
      wd_q    <= '0;
      dout_q  <= '0;
      step    <= '0;
      flag_q  <= 1'b0;
      err_q   <= 1'b0;
      retry_q <= 1'b0;
      for (int i = 0; i < NFIFO; i++) begin
        d_base[i] <= '0;
        d_mask[i] <= '0;
        d_in[i]   <= '0;
        d_out[i]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          sel_q   <= cmd_sel;
          wd_q    <= cmd_wdata;
          dout_q  <= '0;
          step    <= '0;
          flag_q  <= 1'b0;
          err_q   <= 1'b0;
          retry_q <= 1'b0;
          if (cmd_op == OP_BIND) begin
            d_base[cmd_sel] <= cmd_base;
            st <= (cmd_base != '0) ? S_REQ : S_RSP;
          end else if (cmd_op > OP_PUT) begin
            err_q <= 1'b1;
            st    <= S_RSP;
          end else if (d_base[cmd_sel] == '0) begin
            flag_q <= (cmd_op != OP_FULL);
            st     <= S_RSP;
          end else begin
            st <= S_REQ;
          end
        end
        S_REQ: begin
          if (bus_gnt) begin
            step <= '0;
            st   <= S_MEM;
          end else if (bus_fail) begin
            err_q <= 1'b1;
            st    <= S_RSP;
          end
        end
        S_MEM: if (mem_done) begin
          step <= step + 2'd1;
          case (op_q)
            OP_BIND: begin
              if (step == 2'd0) d_mask[sel_q] <= mem_rdata;
              else if (step == 2'd1) d_in[sel_q] <= mem_rdata;
              else begin
                d_out[sel_q] <= mem_rdata;
                st <= S_REL;
              end
            end
            OP_EMPTY: begin
              flag_q <= (mem_rdata == cur_out);
              st     <= S_REL;
            end
            OP_FULL: begin
              flag_q <= (in_nxt == mem_rdata);
              st     <= S_REL;
            end
            OP_PUT: begin
              if (step == 2'd0) begin
                if (in_nxt == mem_rdata) begin
                  retry_q <= 1'b1;
                  st      <= S_REL;
                end
              end else if (step == 2'd2) begin
                d_in[sel_q] <= in_nxt;
                st <= S_REL;
              end
            end
            default: if (is_take) begin
              if (step == 2'd0) begin
                if (mem_rdata == cur_out) begin
                  flag_q  <= (op_q == OP_TAKE);
                  retry_q <= (op_q == OP_WAIT);
                  st      <= S_REL;
                end
              end else if (step == 2'd1) begin
                dout_q <= mem_rdata;
              end else begin
                d_out[sel_q] <= out_nxt;
                st <= S_REL;
              end
            end else begin
              st <= S_REL;
            end
          endcase
        end
        S_REL: begin
          if (retry_q) begin
            retry_q <= 1'b0;
            st      <= S_REQ;
          end else begin
            st <= S_RSP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_fifo_accessor_chk.sv
module ring_fifo_accessor_chk #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_done
);
  assert_mem_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_req && bus_gnt));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_rsp_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_req);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_req && !mem_req && !rsp_valid));
endmodule

bind ring_fifo_accessor ring_fifo_accessor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done)
);

// File: tb/test_ring_fifo_accessor.sv
`timescale 1ns/1ps
module test_ring_fifo_accessor;
  localparam int NFIFO = 4, AW = 20, DW = 8, SELW = 2;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [SELW-1:0] cmd_sel = 0;
  logic [AW-1:0] cmd_base = 0;
  logic [DW-1:0] cmd_wdata = 0;
  logic rsp_valid, rsp_flag, rsp_err;
  logic [DW-1:0] rsp_data;
  logic bus_req, bus_gnt = 0, bus_fail = 0;
  logic mem_req, mem_we, mem_done = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = 0;

  ring_fifo_accessor #(.NFIFO(NFIFO), .AW(AW), .DW(DW)) i_ring_fifo_accessor (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_base(cmd_base), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_fail(bus_fail),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_rdata(mem_rdata));

  int checks = 0, errors = 0, rsp_cnt = 0, breq_rises = 0;
  bit fail_mode = 0, breq_prev = 0;
  bit [7:0] mem [int];
  int lg_addr [$];
  bit lg_we [$];
  logic [10:0] exp_q [$];
  string tag_q [$];
  int mb [NFIFO], mm [NFIFO], mi [NFIFO], mo [NFIFO];

  function automatic int A(int x); return x & AMASK; endfunction
  function automatic int rd(int a); return mem.exists(A(a)) ? int'(mem[A(a)]) : 0; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // memory and bus-owner model
  always @(negedge clk) begin
    if (mem_req && !mem_done) begin
      mem_done = 1;
      lg_addr.push_back(int'(mem_addr));
      lg_we.push_back(mem_we);
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      else mem_rdata = 8'(rd(int'(mem_addr)));
    end else mem_done = 0;
    bus_fail = fail_mode && bus_req && !bus_fail;
    bus_gnt  = bus_req && !fail_mode;
    if (bus_req && !breq_prev) breq_rises++;
    breq_prev = bus_req;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R11", "unexpected response", 1, 0);
      else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_flag == e[9], t, "rsp_flag", rsp_flag, e[9]);
        chk(rsp_err == e[8], t, "rsp_err", rsp_err, e[8]);
        if (e[10]) chk(rsp_data == e[7:0], t, "rsp_data", rsp_data, e[7:0]);
      end
      rsp_cnt++;
    end
  end

  task automatic issue(int op, int s, int base, int wd, bit ef, bit ee, bit ec, int ed, string req);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_sel = SELW'(s);
    cmd_base = AW'(base); cmd_wdata = 8'(wd);
    exp_q.push_back({ec, ef, ee, 8'(ed)});
    tag_q.push_back(req);
    n = rsp_cnt;
    @(negedge clk);
    cmd_valid = 0;
    wait (rsp_cnt == n + 1);
  endtask

  task automatic clr_log(); lg_addr.delete(); lg_we.delete(); endtask

  task automatic bind_ring(int s, int base);
    clr_log();
    issue(0, s, base, 0, 0, 0, 0, 0, "R3");
    mb[s] = base; mm[s] = rd(base - 3); mi[s] = rd(base - 2); mo[s] = rd(base - 1);
    chk(lg_addr.size() == 3, "R3", "bind access count", lg_addr.size(), 3);
    if (lg_addr.size() == 3) begin
      chk(lg_addr[0] == A(base - 3) && !lg_we[0], "R2", "mask addr", lg_addr[0], A(base - 3));
      chk(lg_addr[1] == A(base - 2) && !lg_we[1], "R2", "in-index addr", lg_addr[1], A(base - 2));
      chk(lg_addr[2] == A(base - 1) && !lg_we[2], "R2", "out-index addr", lg_addr[2], A(base - 1));
    end
  endtask

  task automatic put(int s, int v);
    int wa;
    wa = A(mb[s] + mi[s]);
    issue(5, s, 0, v, 0, 0, 0, 0, "R8");
    mi[s] = (mi[s] + 1) & mm[s];
    chk(rd(wa) == v, "R8", "byte stored", rd(wa), v);
    chk(rd(mb[s] - 2) == mi[s], "R8", "in-index written back", rd(mb[s] - 2), mi[s]);
  endtask

  task automatic take(int s);
    if (rd(mb[s] - 2) == mo[s]) begin
      clr_log();
      issue(3, s, 0, 0, 1, 0, 0, 0, "R6");
      chk(lg_addr.size() == 1, "R6", "empty take accesses", lg_addr.size(), 1);
    end else begin
      issue(3, s, 0, 0, 0, 0, 1, rd(mb[s] + mo[s]), "R6");
      mo[s] = (mo[s] + 1) & mm[s];
      chk(rd(mb[s] - 1) == mo[s], "R6", "out-index written back", rd(mb[s] - 1), mo[s]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int r0;
    // ring 0: base 0x1000, 8 entries; ring 1: base 2, 4 entries (header wraps); ring 3: 2 entries, full
    mem[A(32'h1000 - 3)] = 7; mem[A(32'h1000 - 2)] = 0; mem[A(32'h1000 - 1)] = 0;
    mem[A(-1)] = 3; mem[0] = 2; mem[1] = 2;
    mem[32'h7FFD] = 1; mem[32'h7FFE] = 0; mem[32'h7FFF] = 1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1, "R1", "cmd_ready", cmd_ready, 1);
    chk(bus_req == 0 && mem_req == 0 && rsp_valid == 0, "R1", "idle outputs", {bus_req, mem_req, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // unbound descriptor 2: no bus traffic
    r0 = breq_rises;
    issue(1, 2, 0, 0, 1, 0, 0, 0, "R4");
    issue(2, 2, 0, 0, 0, 0, 0, 0, "R5");
    issue(3, 2, 0, 0, 1, 0, 0, 0, "R6");
    issue(4, 2, 0, 0, 1, 0, 0, 0, "R7");
    issue(5, 2, 0, 9, 1, 0, 0, 0, "R8");
    issue(6, 2, 0, 0, 0, 1, 0, 0, "R11");
    issue(0, 2, 0, 0, 0, 0, 0, 0, "R3");
    chk(breq_rises == r0, "R1", "bus requests on unbound ring", breq_rises - r0, 0);

    bind_ring(0, 32'h1000);
    bind_ring(1, 2);
    bind_ring(3, 32'h8000);

    issue(1, 0, 0, 0, 1, 0, 0, 0, "R4");
    clr_log();
    put(0, 8'hA5);
    chk(lg_addr.size() == 3 && lg_addr[0] == A(32'h1000 - 1) && lg_addr[1] == 32'h1000,
        "R8", "append access order", lg_addr.size(), 3);
    issue(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 6; k++) put(0, 8'h10 + k);
    issue(2, 0, 0, 0, 1, 0, 0, 0, "R5");
    issue(2, 1, 0, 0, 0, 0, 0, 0, "R12");
    for (int k = 0; k < 8; k++) take(0);

    // refused bus request
    fail_mode = 1;
    clr_log();
    issue(5, 0, 0, 8'h99, 0, 1, 0, 0, "R9");
    chk(lg_addr.size() == 0, "R9", "memory cycles after refusal", lg_addr.size(), 0);
    fail_mode = 0;
    repeat (2) @(negedge clk);
    put(0, 8'h42);
    chk(rd(32'h1007) == 8'h42, "R9", "append slot unchanged by refusal", rd(32'h1007), 8'h42);
    take(0);

    // waiting take on ring 1 with a late producer
    r0 = breq_rises;
    fork
      begin
        repeat (40) @(posedge clk);
        #1;
        mem[4] = 8'h3C; mem[0] = 3;
      end
      issue(4, 1, 0, 0, 0, 0, 1, 8'h3C, "R7");
    join
    chk(breq_rises - r0 >= 2, "R7", "polls before data", breq_rises - r0, 2);
    chk(rd(1) == 3, "R7", "out-index after waiting take", rd(1), 3);

    // append on a full ring 3 with a late consumer
    r0 = breq_rises;
    fork
      begin
        repeat (40) @(posedge clk);
        #1;
        mem[32'h7FFF] = 0;
      end
      issue(5, 3, 0, 8'h77, 0, 0, 0, 0, "R8");
    join
    chk(breq_rises - r0 >= 2, "R8", "polls while full", breq_rises - r0, 2);
    chk(rd(32'h8000) == 8'h77, "R8", "byte stored after wait", rd(32'h8000), 8'h77);
    chk(rd(32'h7FFE) == 1, "R8", "in-index after wait", rd(32'h7FFE), 1);

    // ring 0 state unaffected by other descriptors
    issue(1, 0, 0, 0, 1, 0, 0, 0, "R12");
    issue(7, 0, 0, 0, 0, 1, 0, 0, "R11");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule